// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and calendar date for a low-power real-time clock. It holds seconds, minutes and hours in a 24-hour system, plus day of month, day of week, month and a two-digit year. A prescaler counts enable pulses from a 32.768 kHz timebase and makes one advance per second. Every carry from seconds up to the year settles in the same clock cycle as that advance. Month length is applied automatically, and February gains its 29th day in years divisible by four.

A serial interface uses a hold input to freeze the counters while a new time is written through a parallel load port. The full state is always visible as one packed 48-bit word, which a shift register can capture. Every field is a pair of BCD digits except the month, which is a binary nibble from 1 to 12, and the day of week, a nibble from 0 to 6.

Top module: `cal_bcd_clock`

## Requirements
- R1: After reset the state reads 00:00:00, day 01, day of week 0, month 1 and year 00.
- R2: The advance occurs after exactly 2^DIV_BITS enable pulses (default 15 bits, so 32768 pulses), as a one-cycle pulse on `sec_pulse`. While `hold` is high the prescaler count is cleared, so a full 2^DIV_BITS pulses are needed after `hold` is released.
- R3: Seconds count in BCD from 00 to 59. An advance at 59 gives 00 and carries into the minutes.
- R4: Minutes count in BCD from 00 to 59. A carry at 59 gives 00 and carries into the hours.
- R5: Hours count in BCD from 00 to 23. A carry at 23 gives 00 and advances the day.
- R6: The day of week advances at each midnight and wraps from 6 to 0.
- R7: The day rolls to 01 and the month advances when the day passes the month's last day. April, June, September and November have 30 days. January, March, May, July, August, October and December have 31.
- R8: February ends on day 28. In years whose BCD value is divisible by 4 (00, 12 and 24 included), it ends on day 29 instead.
- R9: The month is binary from 1 to 12 (4'hC) and wraps from 12 to 1 with a carry into the year. The BCD year wraps from 99 to 00.
- R10: While `hold` is high the state does not count. If `load` is also high, the state takes `load_val` at the next clock edge.
- R11: A `load` while `hold` is low is ignored.
- R12: The packed layout of `now` and `load_val` is: [7:0] seconds, [15:8] minutes, [23:16] hours, [31:24] day, [35:32] day of week, [39:36] month, [47:40] year.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-cycle enable at the 32.768 kHz rate |
| hold | input | 1 | Freeze counting and clear the prescaler |
| load | input | 1 | Write `load_val` into the state while `hold` is high |
| load_val | input | 48 | Packed new time and date (R12 layout) |
| now | output | 48 | Packed current time and date (R12 layout) |
| sec_pulse | output | 1 | One-cycle pulse on each one-second advance |

## Verification
The richest collision occurs when the seconds carry and the month-end carry land on the same advance. On that edge the day of week may also wrap, and so may the year. Each case is provoked by loading, under hold, a state one second before midnight on a month's last day. For December 31st of year 99 with day of week 6, every field wraps at once. After hold is released, exactly one prescaler period of enables is applied, and every field of the packed word is compared against the date worked out by hand.

// File: rtl/cal_pkg.sv
package cal_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [3:0] mon;
        logic [3:0] wday;
        logic [7:0] day;
        logic [7:0] hour;
        logic [7:0] min;
        logic [7:0] sec;
    } cal_t;

    localparam int CAL_W = $bits(cal_t);

    localparam logic [7:0] SEC_TOP  = 8'h59;
    localparam logic [7:0] MIN_TOP  = 8'h59;
    localparam logic [7:0] HOUR_TOP = 8'h23;
    localparam logic [7:0] YEAR_TOP = 8'h99;
    localparam logic [3:0] WDAY_TOP = 4'd6;
    localparam logic [3:0] MON_TOP  = 4'hC;

    localparam cal_t CAL_RESET = '{year: 8'h00, mon: 4'h1, wday: 4'h0,
                                   day: 8'h01, hour: 8'h00, min: 8'h00,
                                   sec: 8'h00};

    typedef struct packed {
        logic [7:0] val;
        logic       wrap;
    } step_t;

    function automatic step_t bcd_step(input logic [7:0] v,
                                       input logic [7:0] top,
                                       input logic [7:0] base);
        step_t r;
        if (v == top) begin
            r.val  = base;
            r.wrap = 1'b1;
        end else begin
            r.wrap = 1'b0;
            if (v[3:0] == 4'd9) r.val = {v[7:4] + 4'd1, 4'd0};
            else                r.val = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

    // (10*t + u) mod 4 == (2*t + u) mod 4
    function automatic logic leap_year(input logic [7:0] y);
        logic [3:0] s;
        s = {2'b00, y[4], 1'b0} + y[3:0];
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last(input logic [3:0] m,
                                              input logic [7:0] y);
        case (m)
            4'd2:                    return leap_year(y) ? 8'h29 : 8'h28;
            4'd4, 4'd6, 4'd9, 4'd11: return 8'h30;
            default:                 return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int DIV_BITS = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic hold,
    output logic adv
);
    generate
        if (DIV_BITS == 0) begin : g_direct
            assign adv = tick_en && !hold;
        end else begin : g_count
            localparam logic [DIV_BITS-1:0] CNT_LAST = '1;
            logic [DIV_BITS-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || hold)  cnt <= '0;
                else if (tick_en) cnt <= cnt + 1'b1;
            end
            assign adv = tick_en && !hold && (cnt == CNT_LAST);
        end
    endgenerate
endmodule

// File: rtl/cal_clock_hms.sv
module cal_clock_hms
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       load,
    input  logic       adv,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    output logic [7:0] sec,
    output logic [7:0] min,
    output logic [7:0] hour,
    output logic       day_adv
);
    step_t s_nx, m_nx, h_nx;

    always_comb begin
        s_nx = bcd_step(sec, SEC_TOP, 8'h00);
        m_nx = bcd_step(min, MIN_TOP, 8'h00);
        h_nx = bcd_step(hour, HOUR_TOP, 8'h00);
    end

    assign day_adv = adv && s_nx.wrap && m_nx.wrap && h_nx.wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            sec  <= CAL_RESET.sec;
            min  <= CAL_RESET.min;
            hour <= CAL_RESET.hour;
        end else if (hold) begin
            if (load) begin
                sec  <= ld_sec;
                min  <= ld_min;
                hour <= ld_hour;
            end
        end else if (adv) begin
            sec <= s_nx.val;
            if (s_nx.wrap) begin
                min <= m_nx.val;
                if (m_nx.wrap) hour <= h_nx.val;
            end
        end
    end
endmodule

// File: rtl/cal_clock_date.sv
module cal_clock_date
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold,
    input  logic       load,
    input  logic       day_adv,
    input  logic [7:0] ld_day,
    input  logic [3:0] ld_wday,
    input  logic [3:0] ld_mon,
    input  logic [7:0] ld_year,
    output logic [7:0] day,
    output logic [3:0] wday,
    output logic [3:0] mon,
    output logic [7:0] year
);
    step_t d_nx, y_nx;
    logic  mon_end, year_end;

    always_comb begin
        d_nx     = bcd_step(day, month_last(mon, year), 8'h01);
        y_nx     = bcd_step(year, YEAR_TOP, 8'h00);
        mon_end  = (mon == MON_TOP);
        year_end = d_nx.wrap && mon_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            day  <= CAL_RESET.day;
            wday <= CAL_RESET.wday;
            mon  <= CAL_RESET.mon;
            year <= CAL_RESET.year;
        end else if (hold) begin
            if (load) begin
                day  <= ld_day;
                wday <= ld_wday;
                mon  <= ld_mon;
                year <= ld_year;
            end
        end else if (day_adv) begin
            wday <= (wday == WDAY_TOP) ? 4'd0 : wday + 4'd1;
            day  <= d_nx.val;
            if (d_nx.wrap) mon <= mon_end ? 4'd1 : mon + 4'd1;
            if (year_end)  year <= y_nx.val;
        end
    end
endmodule

// File: rtl/cal_bcd_clock.sv
module cal_bcd_clock
    import cal_pkg::*;
#(
    parameter int DIV_BITS = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic             hold,
    input  logic             load,
    input  logic [CAL_W-1:0] load_val,
    output logic [CAL_W-1:0] now,
    output logic             sec_pulse
);
    cal_t ld, cur;
    logic adv, day_adv;

    assign ld = cal_t'(load_val);

    cal_prescaler #(.DIV_BITS(DIV_BITS)) u_div (
        .clk(clk), .rst(rst), .tick_en(tick_en), .hold(hold), .adv(adv)
    );

    cal_clock_hms u_hms (
        .clk(clk), .rst(rst), .hold(hold), .load(load), .adv(adv),
        .ld_sec(ld.sec), .ld_min(ld.min), .ld_hour(ld.hour),
        .sec(cur.sec), .min(cur.min), .hour(cur.hour), .day_adv(day_adv)
    );

    cal_clock_date u_date (
        .clk(clk), .rst(rst), .hold(hold), .load(load), .day_adv(day_adv),
        .ld_day(ld.day), .ld_wday(ld.wday), .ld_mon(ld.mon), .ld_year(ld.year),
        .day(cur.day), .wday(cur.wday), .mon(cur.mon), .year(cur.year)
    );

    assign now       = cur;
    assign sec_pulse = adv;
endmodule

// File: rtl/cal_bcd_clock_chk.sv
module cal_bcd_clock_chk
    import cal_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             hold,
    input logic             load,
    input logic [CAL_W-1:0] load_val,
    input logic [CAL_W-1:0] now,
    input logic             sec_pulse
);
    cal_t n;
    assign n = cal_t'(now);

    AST_SEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        n.sec <= SEC_TOP && n.sec[3:0] <= 4'd9); // R3
    AST_MIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        n.min <= MIN_TOP && n.min[3:0] <= 4'd9); // R4
    AST_HOUR_RANGE: assert property (@(posedge clk) disable iff (rst)
        n.hour <= HOUR_TOP && n.hour[3:0] <= 4'd9); // R5
    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        n.wday <= WDAY_TOP); // R6
    AST_DAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        n.day >= 8'h01 && n.day <= 8'h31); // R7
    AST_MON_RANGE: assert property (@(posedge clk) disable iff (rst)
        n.mon >= 4'd1 && n.mon <= MON_TOP); // R9
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold && !load |=> $stable(now)); // R10
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        hold && load |=> now == $past(load_val)); // R10
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !hold && !sec_pulse |=> $stable(now)); // R11
    AST_TICK_MOVES: assert property (@(posedge clk) disable iff (rst)
        !hold && sec_pulse |=> n.sec != $past(n.sec)); // R2
endmodule

bind cal_bcd_clock cal_bcd_clock_chk u_chk (
    .clk(clk), .rst(rst), .hold(hold), .load(load),
    .load_val(load_val), .now(now), .sec_pulse(sec_pulse)
);

// File: tb/cal_bcd_clock_bench.sv
module cal_bcd_clock_bench;
    localparam int DIV_BITS = 3;
    localparam int PERIOD   = 1 << DIV_BITS;
    localparam int NVEC     = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        hold = 1'b0;
    logic        load = 1'b0;
    logic [47:0] load_val = '0;
    logic [47:0] now;
    logic        sec_pulse;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (sec_pulse) pulses++;

    cal_bcd_clock #(.DIV_BITS(DIV_BITS)) u_cal_bcd_clock (
        .clk(clk), .rst(rst), .tick_en(tick_en), .hold(hold), .load(load),
        .load_val(load_val), .now(now), .sec_pulse(sec_pulse)
    );

    // {start, expected after one advance}; layout yy_m_w_dd_hh_mm_ss
    localparam logic [95:0] VEC [NVEC] = '{
        {48'h23_5_2_14_10_20_30, 48'h23_5_2_14_10_20_31},
        {48'h23_5_2_14_10_20_59, 48'h23_5_2_14_10_21_00},
        {48'h23_5_2_14_10_59_59, 48'h23_5_2_14_11_00_00},
        {48'h23_5_2_14_23_59_59, 48'h23_5_3_15_00_00_00},
        {48'h23_5_6_14_23_59_59, 48'h23_5_0_15_00_00_00},
        {48'h23_4_1_30_23_59_59, 48'h23_5_2_01_00_00_00},
        {48'h23_5_1_30_23_59_59, 48'h23_5_2_31_00_00_00},
        {48'h23_9_0_30_23_59_59, 48'h23_A_1_01_00_00_00},
        {48'h23_2_3_28_23_59_59, 48'h23_3_4_01_00_00_00},
        {48'h24_2_3_28_23_59_59, 48'h24_2_4_29_00_00_00},
        {48'h24_2_4_29_23_59_59, 48'h24_3_5_01_00_00_00},
        {48'h00_2_5_28_23_59_59, 48'h00_2_6_29_00_00_00},
        {48'h12_2_0_28_23_59_59, 48'h12_2_1_29_00_00_00},
        {48'h10_2_0_28_23_59_59, 48'h10_3_1_01_00_00_00},
        {48'h99_C_6_31_23_59_59, 48'h00_1_0_01_00_00_00},
        {48'h19_C_2_31_23_59_59, 48'h20_1_3_01_00_00_00}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0, 1:                return "R3";
            2:                   return "R4";
            3:                   return "R5";
            4:                   return "R6";
            5, 6, 7:             return "R7";
            8, 9, 10, 11, 12, 13: return "R8";
            default:             return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [47:0] act,
                         input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic load_state(input logic [47:0] v);
        @(negedge clk);
        hold = 1'b1; load = 1'b1; load_val = v;
        @(negedge clk);
        hold = 1'b0; load = 1'b0;
    endtask

    task automatic enables(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_en = 1'b1;
        end
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset state", now, 48'h00_1_0_01_00_00_00);

        // R2: one pulse short leaves time alone, the last one advances it
        p0 = pulses;
        enables(PERIOD - 1);
        check("R2 short of period", now, 48'h00_1_0_01_00_00_00);
        enables(1);
        check("R2 full period", now, 48'h00_1_0_01_00_00_01);
        check("R2 one pulse", 48'(pulses - p0), 48'd1);

        // R2: hold clears the prescaler
        enables(PERIOD - 3);
        @(negedge clk); hold = 1'b1;
        @(negedge clk); hold = 1'b0;
        enables(PERIOD - 1);
        check("R2 prescaler cleared by hold", now, 48'h00_1_0_01_00_00_01);
        enables(1);
        check("R2 after hold", now, 48'h00_1_0_01_00_00_02);

        // table of single-advance cases
        for (int i = 0; i < NVEC; i++) begin
            load_state(VEC[i][95:48]);
            enables(PERIOD);
            check(vec_tag(i), now, VEC[i][47:0]);
        end

        // R10: hold freezes counting despite enables
        load_state(48'h23_5_2_14_10_20_30);
        @(negedge clk); hold = 1'b1;
        enables(4 * PERIOD);
        check("R10 hold freeze", now, 48'h23_5_2_14_10_20_30);
        @(negedge clk); hold = 1'b0;

        // R11: load without hold is ignored
        @(negedge clk); load = 1'b1; load_val = 48'h11_3_3_03_03_03_03;
        @(negedge clk); load = 1'b0;
        @(negedge clk);
        check("R11 load ignored", now, 48'h23_5_2_14_10_20_30);

        // R12: field positions
        load_state(48'h47_B_5_26_18_42_07);
        check("R12 sec",  48'(now[7:0]),   48'h07);
        check("R12 min",  48'(now[15:8]),  48'h42);
        check("R12 hour", 48'(now[23:16]), 48'h18);
        check("R12 day",  48'(now[31:24]), 48'h26);
        check("R12 wday", 48'(now[35:32]), 48'h5);
        check("R12 mon",  48'(now[39:36]), 48'hB);
        check("R12 year", 48'(now[47:40]), 48'h47);

        // R1: reset restores the initial state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 reset again", now, 48'h00_1_0_01_00_00_00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule